// File: doc/BRIEF.md
# Spare Metadata Protection Code Generator

This block computes the 12-bit protection code that guards the eight metadata bytes in the spare area of a NAND page. Those bytes sit at spare offsets 0x04 through 0x0B. They arrive together as one 64-bit word, qualified by a single-cycle valid strobe. One clock later the block presents a 16-bit field that can be written straight into spare offsets 0x0C and 0x0D. The four unused upper bits of that field are forced to ones.

The code is built from two families of parity bits:
- Three bits look inside the byte. They take the XOR of all eight bytes and compute its parity under a mask of bit positions whose position-index bit is clear.
- Three more bits use the same XOR under the complementary masks, where the position-index bit is set.
- Six bits work across bytes. Each is the full parity of the group of bytes whose byte-index bit j is clear, or of the group where it is set.

A page writer drives the strobe once per page, or on consecutive cycles when it streams several pages. It then copies the registered field into the spare buffer, low byte first.

Top module: `spare_meta_ecc_gen`

## Requirements
- R1: While rst_n is low, out_vld is 0 and out_code is 16'hF000. These values remain until the first strobe after reset.
- R2: out_vld is 1 in the cycle after each cycle in which in_vld was sampled high, and 0 in every other cycle.
- R3: out_code[15:12] is always 4'b1111.
- R4: Let X be the XOR of all eight input bytes. Code bits 0, 1 and 2 are the odd-parity of X masked with 0x55, 0x33 and 0x0F, respectively.
- R5: Code bits 6, 7 and 8 are the odd-parity of X masked with 0xAA, 0xCC and 0xF0, respectively.
- R6: Code bit 3 is the parity of all bits of bytes 0, 2, 4 and 6. Code bit 4 covers bytes 0, 1, 4 and 5. Code bit 5 covers bytes 0, 1, 2 and 3.
- R7: Code bit 9 is the parity of all bits of bytes 1, 3, 5 and 7. Code bit 10 covers bytes 2, 3, 6 and 7. Code bit 11 covers bytes 4, 5, 6 and 7.
- R8: Byte k of the metadata (spare offset 0x04+k) is carried on in_bytes[8k+7:8k]. out_code[7:0] is the byte stored at offset 0x0C, and out_code[15:8] is the byte stored at offset 0x0D.
- R9: When in_vld is low, out_code keeps its value regardless of in_bytes.
- R10: Strobes on consecutive cycles each yield their own code one cycle later, with no gap and no loss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Metadata word valid strobe |
| in_bytes | input | 64 | Eight metadata bytes, byte k in bits 8k+7:8k |
| out_vld | output | 1 | Code field valid, one cycle after in_vld |
| out_code | output | 16 | Registered code field, high nibble all ones |

## Verification
Two events can fall in the same clock edge. A fresh word can be captured at the very edge where the previous word's code is being presented, and a load can collide with a hold. The bench provokes both with back-to-back strobes carrying different words, followed immediately by a strobe-free stretch during which in_bytes keeps changing. At each falling edge it judges the output against a model that flips code bits one set input bit at a time. After a run of strobes, the last code must stay frozen and out_vld must drop.

// File: rtl/spare_ecc_pkg.sv
package spare_ecc_pkg;

  localparam int DEF_LOG_BYTES = 3;
  localparam int DEF_LOG_BITS  = 3;
  localparam int DEF_FIELD_W   = 16;

  // mask of bit positions b (< bw) whose index bit j equals pol
  function automatic logic [31:0] pos_mask(input int bw, input int j, input logic pol);
    logic [31:0] m;
    m = '0;
    for (int b = 0; b < bw; b++) begin
      if ((((b >> j) & 1) == 1) == pol) m[b] = 1'b1;
    end
    return m;
  endfunction

  // true when byte index k has bit j equal to pol
  function automatic logic idx_sel(input int k, input int j, input logic pol);
    return ((((k >> j) & 1) == 1) == pol);
  endfunction

endpackage

// File: rtl/sec_group_xor.sv
module sec_group_xor #(
  parameter int LOG_BYTES = spare_ecc_pkg::DEF_LOG_BYTES,
  parameter int BYTE_W    = 8
) (
  input  logic [(BYTE_W << LOG_BYTES)-1:0] bytes_i,
  output logic [LOG_BYTES*BYTE_W-1:0]      grp_lo_o,
  output logic [LOG_BYTES*BYTE_W-1:0]      grp_hi_o,
  output logic [BYTE_W-1:0]                all_o
);
  localparam int NUM_BYTES = 1 << LOG_BYTES;

  always_comb begin
    all_o = '0;
    for (int k = 0; k < NUM_BYTES; k++) all_o ^= bytes_i[k*BYTE_W +: BYTE_W];
  end

  for (genvar j = 0; j < LOG_BYTES; j++) begin : g_grp
    logic [BYTE_W-1:0] acc_lo;
    logic [BYTE_W-1:0] acc_hi;
    always_comb begin
      acc_lo = '0;
      acc_hi = '0;
      for (int k = 0; k < NUM_BYTES; k++) begin
        if (spare_ecc_pkg::idx_sel(k, j, 1'b1)) acc_hi ^= bytes_i[k*BYTE_W +: BYTE_W];
        else                                    acc_lo ^= bytes_i[k*BYTE_W +: BYTE_W];
      end
    end
    assign grp_lo_o[j*BYTE_W +: BYTE_W] = acc_lo;
    assign grp_hi_o[j*BYTE_W +: BYTE_W] = acc_hi;
  end
endmodule

// File: rtl/sec_mask_parity.sv
module sec_mask_parity #(
  parameter int LOG_BITS = spare_ecc_pkg::DEF_LOG_BITS,
  parameter int BYTE_W   = 1 << LOG_BITS
) (
  input  logic [BYTE_W-1:0]   word_i,
  output logic [LOG_BITS-1:0] par_lo_o,
  output logic [LOG_BITS-1:0] par_hi_o
);
  for (genvar j = 0; j < LOG_BITS; j++) begin : g_par
    localparam logic [31:0] M_HI = spare_ecc_pkg::pos_mask(BYTE_W, j, 1'b1);
    localparam logic [31:0] M_LO = spare_ecc_pkg::pos_mask(BYTE_W, j, 1'b0);
    assign par_hi_o[j] = ^(word_i & M_HI[BYTE_W-1:0]);
    assign par_lo_o[j] = ^(word_i & M_LO[BYTE_W-1:0]);
  end
endmodule

// File: rtl/spare_meta_ecc_gen.sv
module spare_meta_ecc_gen #(
  parameter int LOG_BYTES = spare_ecc_pkg::DEF_LOG_BYTES,
  parameter int LOG_BITS  = spare_ecc_pkg::DEF_LOG_BITS,
  parameter int FIELD_W   = spare_ecc_pkg::DEF_FIELD_W,
  localparam int BYTE_W   = 1 << LOG_BITS,
  localparam int IN_W     = BYTE_W << LOG_BYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld,
  input  logic [IN_W-1:0]    in_bytes,
  output logic               out_vld,
  output logic [FIELD_W-1:0] out_code
);
  localparam int CODE_W = 2 * (LOG_BYTES + LOG_BITS);
  localparam int PAD_W  = FIELD_W - CODE_W;
  localparam logic [FIELD_W-1:0] RST_FIELD = {{PAD_W{1'b1}}, {CODE_W{1'b0}}};

  logic                        load_evt;
  logic [LOG_BYTES*BYTE_W-1:0] grp_lo, grp_hi;
  logic [BYTE_W-1:0]           all_x;
  logic [LOG_BITS-1:0]         par_lo, par_hi;
  logic [LOG_BYTES-1:0]        idx_lo, idx_hi;
  logic [FIELD_W-1:0]          code_nxt;

  assign load_evt = in_vld;

  sec_group_xor #(.LOG_BYTES(LOG_BYTES), .BYTE_W(BYTE_W)) u_grp (
    .bytes_i  (in_bytes),
    .grp_lo_o (grp_lo),
    .grp_hi_o (grp_hi),
    .all_o    (all_x)
  );

  sec_mask_parity #(.LOG_BITS(LOG_BITS), .BYTE_W(BYTE_W)) u_par (
    .word_i   (all_x),
    .par_lo_o (par_lo),
    .par_hi_o (par_hi)
  );

  for (genvar j = 0; j < LOG_BYTES; j++) begin : g_idx
    assign idx_lo[j] = ^grp_lo[j*BYTE_W +: BYTE_W];
    assign idx_hi[j] = ^grp_hi[j*BYTE_W +: BYTE_W];
  end

  // layout: position-low | index-low | position-high | index-high | pad
  assign code_nxt = {{PAD_W{1'b1}}, idx_hi, par_hi, idx_lo, par_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_code <= RST_FIELD;
    end else begin
      out_vld <= load_evt;
      if (load_evt) out_code <= code_nxt;
    end
  end
endmodule

// File: rtl/spare_meta_ecc_chk.sv
module spare_meta_ecc_chk #(
  parameter int LOG_BYTES = spare_ecc_pkg::DEF_LOG_BYTES,
  parameter int LOG_BITS  = spare_ecc_pkg::DEF_LOG_BITS,
  parameter int FIELD_W   = spare_ecc_pkg::DEF_FIELD_W,
  localparam int BYTE_W   = 1 << LOG_BITS,
  localparam int IN_W     = BYTE_W << LOG_BYTES
) (
  input logic               clk,
  input logic               rst_n,
  input logic               load_evt,
  input logic [IN_W-1:0]    in_bytes,
  input logic               out_vld,
  input logic [FIELD_W-1:0] out_code
);
  localparam int CODE_W = 2 * (LOG_BYTES + LOG_BITS);
  localparam int PAD_W  = FIELD_W - CODE_W;
  localparam int B_PLO  = LOG_BITS - 1;
  localparam int B_ILO  = LOG_BITS + LOG_BYTES - 1;
  localparam int B_PHI  = 2*LOG_BITS + LOG_BYTES - 1;
  localparam int B_IHI  = CODE_W - 1;

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_vld && out_code == {{PAD_W{1'b1}}, {CODE_W{1'b0}}}));

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> out_vld);

  // R2
  vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> !out_vld);

  // R9
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(out_code));

  // R3
  pad_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_code[FIELD_W-1:CODE_W] == {PAD_W{1'b1}});

  // R5 (top position masks split the all-byte XOR, so together they give total parity)
  pos_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> ((out_code[B_PLO] ^ out_code[B_PHI]) == $past(^in_bytes)));

  // R7 (the two top byte groups cover every byte once)
  idx_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> ((out_code[B_ILO] ^ out_code[B_IHI]) == $past(^in_bytes)));
endmodule

bind spare_meta_ecc_gen spare_meta_ecc_chk #(
  .LOG_BYTES(LOG_BYTES), .LOG_BITS(LOG_BITS), .FIELD_W(FIELD_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .load_evt (load_evt),
  .in_bytes (in_bytes),
  .out_vld  (out_vld),
  .out_code (out_code)
);

// File: tb/test_spare_meta_ecc_gen.sv
module test_spare_meta_ecc_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [63:0] in_bytes;
  logic        out_vld;
  logic [15:0] out_code;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;

  always #5 clk = ~clk;

  spare_meta_ecc_gen i_spare_meta_ecc_gen (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_bytes(in_bytes),
    .out_vld(out_vld), .out_code(out_code)
  );

  // hand-derived vectors; byte k at bits 8k+7:8k (R8)
  localparam int NV = 7;
  localparam logic [63:0] VEC_IN [NV] = '{
    64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h8000_0000_0000_0000,
    64'h80, 64'h0100_0000_0000_0000, 64'h0000_0000_1000_0000};
  localparam logic [15:0] VEC_EXP [NV] = '{
    16'hF000, 16'hF000, 16'hF03F, 16'hFFC0, 16'hF1F8, 16'hFE07, 16'hF723};

  // every set bit flips one code bit per position-index bit and per byte-index bit
  function automatic logic [15:0] model(input logic [63:0] d);
    logic [15:0] c;
    c = 16'hF000;
    for (int k = 0; k < 8; k++)
      for (int b = 0; b < 8; b++)
        if (d[8*k+b])
          for (int j = 0; j < 3; j++) begin
            if (((b >> j) & 1) == 1) c[6+j] = ~c[6+j]; else c[j]   = ~c[j];
            if (((k >> j) & 1) == 1) c[9+j] = ~c[9+j]; else c[3+j] = ~c[3+j];
          end
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic strobe_and_check(input string tag, input logic [63:0] d, input logic [15:0] e);
    @(negedge clk); in_vld = 1'b1; in_bytes = d;
    @(negedge clk); in_vld = 1'b0;
    chk({tag, " vld"}, {31'd0, out_vld}, 32'd1);
    chk(tag, {16'd0, out_code}, {16'd0, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    logic [15:0] prev;
    rst_n = 1'b0; in_vld = 1'b0; in_bytes = 64'hDEAD_BEEF_0123_4567;
    repeat (3) @(negedge clk);
    chk("R1 reset vld", {31'd0, out_vld}, 32'd0);
    chk("R1 reset code", {16'd0, out_code}, 32'hF000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {16'd0, out_code}, 32'hF000);

    // table walk: R4 R5 R6 R7 R8 R3
    for (int i = 0; i < NV; i++) begin
      strobe_and_check("R4/R5 R6 R7 table", VEC_IN[i], VEC_EXP[i]);
      chk("R4/R5 R6 R7 model agrees", {16'd0, model(VEC_IN[i])}, {16'd0, VEC_EXP[i]});
    end

    // R8 byte order: byte 0 = 0x01 gives low byte 0x3F, high byte 0xF0
    strobe_and_check("R8 order", 64'h1, 16'hF03F);
    chk("R8 low byte", {24'd0, out_code[7:0]}, 32'h3F);
    chk("R8 high byte", {24'd0, out_code[15:8]}, 32'hF0);

    // pseudo-random words: R4 R5 R6 R7 R3
    r = 64'h9E37_79B9_7F4A_7C15;
    for (int n = 0; n < 40; n++) begin
      r ^= r << 13; r ^= r >> 7; r ^= r << 17;
      strobe_and_check("R6 R7 random", r, model(r));
      chk("R3 pad", {28'd0, out_code[15:12]}, 32'hF);
    end

    // R10 back-to-back strobes, then R9 hold with changing input
    @(negedge clk); in_vld = 1'b1; in_bytes = 64'h0123_4567_89AB_CDEF;
    @(negedge clk);
    chk("R10 first", {16'd0, out_code}, {16'd0, model(64'h0123_4567_89AB_CDEF)});
    in_bytes = 64'h8000_0000_0000_0001;
    @(negedge clk);
    chk("R10 second", {16'd0, out_code}, {16'd0, model(64'h8000_0000_0000_0001)});
    chk("R10 second vld", {31'd0, out_vld}, 32'd1);
    in_bytes = 64'h0000_00F0_0F00_0000;
    @(negedge clk);
    chk("R10 third", {16'd0, out_code}, {16'd0, model(64'h0000_00F0_0F00_0000)});
    in_vld = 1'b0; in_bytes = 64'hFFFF_0000_FFFF_0001;
    prev = model(64'h0000_00F0_0F00_0000);
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      chk("R2 vld low", {31'd0, out_vld}, 32'd0);
      chk("R9 hold", {16'd0, out_code}, {16'd0, prev});
      in_bytes = in_bytes + 64'h0101_0101_0101_0101;
    end

    // R1 reset in mid-run clears a held code
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset code", {16'd0, out_code}, 32'hF000);
    chk("R1 mid reset vld", {31'd0, out_vld}, 32'd0);
    rst_n = 1'b1;
    strobe_and_check("R2 after reset", 64'h80, 16'hF1F8);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule